// File: doc/BRIEF.md
# Hardware Semaphore and Mailbox Unit

This block lets two processor cores share resources without disturbing each other. It holds eight one-bit semaphores behind a simple synchronous register bus. A core claims a semaphore by reading it. The read returns the semaphore's earlier state and marks the semaphore taken in the same access. A core releases it with an explicit write of zero. Since only one bus access completes per clock, the test-and-set is atomic with no further logic.

Each core also has a 32-bit mailbox and an interrupt register. The interrupt register holds an enable bit and a flag bit, and its interrupt line is high while both bits are set. A status word shows all eight semaphores at once and can be read without side effects. Read data is registered and appears in the cycle after the read strobe.

Top module: `hwsem_top`

## Requirements
- R1: After reset every semaphore is free, both mailboxes and both interrupt registers read zero (enable and flag included), and both interrupt outputs are low.
- R2: A read of the semaphore register at byte offset 4*n (n = 0..7) returns that semaphore's earlier state in bit 0, with all other bits zero, on `rdData` in the next cycle, and leaves the semaphore taken.
- R3: Two back-to-back reads of a free semaphore return 0 and then 1.
- R4: A write to a semaphore register with bit 0 = 0 frees it. A write with bit 0 = 1 changes nothing.
- R5: A read at offset 0x100 returns semaphore n in bit n (1 = taken, 0 = free), with bits 31:8 zero, and changes no semaphore.
- R6: Mailbox 0 at offset 0x44 and mailbox 1 at offset 0x4C each store and return a full 32-bit value.
- R7: Interrupt register 0 is at offset 0x40 and interrupt register 1 is at offset 0x48. Bit 0 is the enable, bit 16 is the flag, and a write loads both bits. Other bits read as zero. `irqOut[k]` is high from the cycle after a write that leaves both bits of register k set.
- R8: Reads of reserved offsets (0x20–0x3C, 0x50–0xFC, and anything above 0x100) return zero. Writes to them change no register and no output.
- R9: `rdData` is zero in any cycle that follows a cycle with no read strobe.
- R10: If `rdEn` and `wrEn` are high in the same cycle, only the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the access; bits 1:0 are ignored |
| rdEn | input | 1 | Read strobe, one access per cycle |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data, valid the cycle after `rdEn` |
| irqOut | output | 2 | Interrupt line per core, enable AND flag |

## Verification
A semaphore bit that is wrong inside the block is only visible through a later read. The bench therefore reads the status word after every change to a semaphore, so a stuck or wrongly cleared bit shows within two cycles, one of them the registered read. A wrong interrupt enable or flag shows on `irqOut` in the cycle right after the write. A decode fault that lets a reserved or dropped write through shows only when the status word, a mailbox or `irqOut` is checked afterwards, so those are checked again after the reserved-offset accesses.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int SEM_CNT    = 8;
  localparam int CHAN_CNT   = 2;
  localparam int WORD_W     = ADDR_W - 2;
  localparam int SEM_IDX_W  = $clog2(SEM_CNT);
  localparam int CHAN_IDX_W = (CHAN_CNT > 1) ? $clog2(CHAN_CNT) : 1;
  localparam int EN_BIT     = 0;
  localparam int FLAG_BIT   = 16;
  localparam int CHAN_STRIDE = 2;

  // word addresses (byte offset / 4)
  localparam logic [WORD_W-1:0] IRQ_BASE_WD  = WORD_W'(16);  // 0x40
  localparam logic [WORD_W-1:0] MBOX_BASE_WD = WORD_W'(17);  // 0x44
  localparam logic [WORD_W-1:0] STAT_WD      = WORD_W'(64);  // 0x100

  typedef enum logic [2:0] {
    SRC_NONE, SRC_SEM, SRC_IRQ, SRC_MBOX, SRC_STAT
  } rdSrc_e;

  typedef struct packed {
    logic                  rdSem;
    logic                  wrSem;
    logic [SEM_IDX_W-1:0]  semIdx;
    logic [CHAN_CNT-1:0]   wrIrq;
    logic [CHAN_CNT-1:0]   wrMbox;
    logic [CHAN_IDX_W-1:0] chan;
    rdSrc_e                rdSrc;
  } busStrobe_t;
endpackage

// File: rtl/hwsem_ctrl.sv
module hwsem_ctrl
  import hwsem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output busStrobe_t        op
);
  logic [WORD_W-1:0] wordIdx;
  logic              wrOk;

  assign wordIdx = addr[ADDR_W-1:2];
  assign wrOk    = wrEn && !rdEn;   // read wins a collision

  always_comb begin
    op       = '0;
    op.rdSrc = SRC_NONE;
    if (wordIdx < WORD_W'(SEM_CNT)) begin
      op.semIdx = wordIdx[SEM_IDX_W-1:0];
      op.rdSem  = rdEn;
      op.wrSem  = wrOk;
      if (rdEn) op.rdSrc = SRC_SEM;
    end else if (wordIdx == STAT_WD) begin
      if (rdEn) op.rdSrc = SRC_STAT;
    end else begin
      for (int c = 0; c < CHAN_CNT; c++) begin
        if (wordIdx == IRQ_BASE_WD + WORD_W'(CHAN_STRIDE * c)) begin
          op.chan     = CHAN_IDX_W'(c);
          op.wrIrq[c] = wrOk;
          if (rdEn) op.rdSrc = SRC_IRQ;
        end
        if (wordIdx == MBOX_BASE_WD + WORD_W'(CHAN_STRIDE * c)) begin
          op.chan      = CHAN_IDX_W'(c);
          op.wrMbox[c] = wrOk;
          if (rdEn) op.rdSrc = SRC_MBOX;
        end
      end
    end
  end

  // R10: a colliding write never produces a write strobe
  p_collision_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn) |-> (!op.wrSem && op.wrIrq == '0 && op.wrMbox == '0));

  // R8: at most one register is written per cycle
  p_single_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({op.wrSem, op.wrIrq, op.wrMbox}));
endmodule

// File: rtl/hwsem_datapath.sv
module hwsem_datapath
  import hwsem_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          op,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [CHAN_CNT-1:0] irqOut
);
  logic [SEM_CNT-1:0]               semReg;
  logic [CHAN_CNT-1:0][DATA_W-1:0]  mboxAll;
  logic [CHAN_CNT-1:0]              irqEnAll;
  logic [CHAN_CNT-1:0]              irqFlagAll;
  logic [DATA_W-1:0]                rdNext;

  // semaphores: read sets, write of zero clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      semReg <= '0;
    end else if (op.rdSem) begin
      semReg[op.semIdx] <= 1'b1;
    end else if (op.wrSem && !wrData[0]) begin
      semReg[op.semIdx] <= 1'b0;
    end
  end

  for (genvar c = 0; c < CHAN_CNT; c++) begin : g_chan
    logic [DATA_W-1:0] mboxQ;
    logic              enQ;
    logic              flagQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mboxQ <= '0;
      end else if (op.wrMbox[c]) begin
        mboxQ <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ   <= 1'b0;
        flagQ <= 1'b0;
      end else if (op.wrIrq[c]) begin
        enQ   <= wrData[EN_BIT];
        flagQ <= wrData[FLAG_BIT];
      end
    end

    assign mboxAll[c]    = mboxQ;
    assign irqEnAll[c]   = enQ;
    assign irqFlagAll[c] = flagQ;
    assign irqOut[c]     = enQ && flagQ;
  end

  always_comb begin
    rdNext = '0;
    unique case (op.rdSrc)
      SRC_SEM:  rdNext = DATA_W'(semReg[op.semIdx]);
      SRC_STAT: rdNext = DATA_W'(semReg);
      SRC_MBOX: rdNext = mboxAll[op.chan];
      SRC_IRQ: begin
        rdNext[EN_BIT]   = irqEnAll[op.chan];
        rdNext[FLAG_BIT] = irqFlagAll[op.chan];
      end
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // R2: a semaphore read leaves the semaphore taken
  p_read_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    op.rdSem |=> semReg[$past(op.semIdx)]);

  // R4: a write of zero frees the semaphore
  p_zero_frees_r4: assert property (@(posedge clk) disable iff (!rstN)
    (op.wrSem && !wrData[0]) |=> !semReg[$past(op.semIdx)]);

  // R4: a write of one leaves all semaphores alone
  p_one_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (op.wrSem && wrData[0]) |=> $stable(semReg));

  // R5: reading the status word changes no semaphore
  p_status_pure_r5: assert property (@(posedge clk) disable iff (!rstN)
    (op.rdSrc == SRC_STAT) |=> $stable(semReg));
endmodule

// File: rtl/hwsem_top.sv
module hwsem_top
  import hwsem_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [CHAN_CNT-1:0] irqOut
);
  busStrobe_t strobes;

  hwsem_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .addr (addr),
    .rdEn (rdEn),
    .wrEn (wrEn),
    .op   (strobes)
  );

  hwsem_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .op     (strobes),
    .wrData (wrData),
    .rdData (rdData),
    .irqOut (irqOut)
  );

  // port-level view of the map, for the checks below
  logic [WORD_W-1:0] chkWord;
  logic              chkResv;
  assign chkWord = addr[ADDR_W-1:2];
  assign chkResv = !((chkWord < WORD_W'(SEM_CNT)) ||
                     (chkWord >= IRQ_BASE_WD &&
                      chkWord <  IRQ_BASE_WD + WORD_W'(CHAN_STRIDE * CHAN_CNT)) ||
                     (chkWord == STAT_WD));

  // R8: a reserved read returns zero
  p_resv_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && chkResv) |=> (rdData == '0));

  // R9: no read strobe, no read data
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

  // R7: an interrupt line only rises after a write
  p_irq0_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut[0]) |-> $past(wrEn));
  p_irq1_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut[1]) |-> $past(wrEn));
endmodule

// File: tb/sim_hwsem_top.sv
`timescale 1ns/1ps
module sim_hwsem_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  irqOut;

  int compared = 0;
  int mismatched = 0;

  typedef struct { logic [31:0] val; string tag; } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  hwsem_top u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic r, input logic w,
                        input logic [31:0] d, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; rdEn = r; wrEn = w; wrData = d;
    if (r) expQ.push_back('{e, tag});
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    access(a, 1'b1, 1'b0, '0, e, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    access(a, 1'b0, 1'b1, d, '0, "");
  endtask

  task automatic idle();
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) begin
    #2;
    if (rstN && rdEn) begin
      if (expQ.size() == 0) begin
        chk("scoreboard underflow", 32'hFFFF_FFFF, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(it.tag, rdData, it.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1..: act=timeout exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irqOut after reset", {30'b0, irqOut}, 32'h0);
    rd(12'h100, 32'h0, "R1 status after reset");
    rd(12'h044, 32'h0, "R1 mailbox0 after reset");
    rd(12'h04C, 32'h0, "R1 mailbox1 after reset");
    rd(12'h040, 32'h0, "R1 irq0 after reset");
    rd(12'h048, 32'h0, "R1 irq1 after reset");

    // R2 / R3 test-and-set, back to back
    rd(12'h00C, 32'h0, "R2 first read of sem3");
    rd(12'h00C, 32'h1, "R3 second read of sem3");
    rd(12'h100, 32'h08, "R5 status shows sem3");
    rd(12'h100, 32'h08, "R5 status read has no side effect");

    // R4 release rules
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h100, 32'h08, "R4 write of one ignored");
    wr(12'h00C, 32'hFFFF_FFFE);
    rd(12'h100, 32'h00, "R4 write of zero frees");

    // R2 at both ends of the range
    rd(12'h000, 32'h0, "R2 read of sem0");
    rd(12'h01C, 32'h0, "R2 read of sem7");
    rd(12'h100, 32'h81, "R5 status sem0 and sem7");

    // R10 read and write together on sem5 (free)
    access(12'h014, 1'b1, 1'b1, 32'h0, 32'h0, "R10 collision read value");
    rd(12'h100, 32'hA1, "R10 collision write dropped");

    // R6 mailboxes
    wr(12'h044, 32'hDEAD_BEEF);
    wr(12'h04C, 32'h1234_5678);
    rd(12'h044, 32'hDEAD_BEEF, "R6 mailbox0");
    rd(12'h04C, 32'h1234_5678, "R6 mailbox1");

    // R7 interrupt registers
    wr(12'h040, 32'hFFFF_FFFF);
    idle();
    chk("R7 irq0 enable and flag", {30'b0, irqOut}, 32'h1);
    rd(12'h040, 32'h0001_0001, "R7 irq0 readback masks unused bits");
    wr(12'h048, 32'h0001_0000);
    idle();
    chk("R7 irq1 flag without enable", {30'b0, irqOut}, 32'h1);
    wr(12'h048, 32'h0001_0001);
    idle();
    chk("R7 irq1 enable and flag", {30'b0, irqOut}, 32'h3);
    wr(12'h040, 32'h0000_0001);
    idle();
    chk("R7 irq0 flag cleared", {30'b0, irqOut}, 32'h2);
    rd(12'h048, 32'h0001_0001, "R7 irq1 readback");

    // R8 reserved offsets
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h050, 32'h0000_0000);
    wr(12'h104, 32'h0000_0000);
    wr(12'h03C, 32'h0001_0001);
    rd(12'h020, 32'h0, "R8 reserved 0x20 reads zero");
    rd(12'h03C, 32'h0, "R8 reserved 0x3C reads zero");
    rd(12'h050, 32'h0, "R8 reserved 0x50 reads zero");
    rd(12'h0FC, 32'h0, "R8 reserved 0xFC reads zero");
    rd(12'h100, 32'hA1, "R8 semaphores untouched");
    rd(12'h044, 32'hDEAD_BEEF, "R8 mailbox0 untouched");
    idle();
    chk("R8 irqOut untouched", {30'b0, irqOut}, 32'h2);

    // R9 idle read data
    idle();
    chk("R9 rdData zero when idle", rdData, 32'h0);

    idle();
    chk("scoreboard drained", expQ.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule